// File: doc/BRIEF.md
# Debug Comparator State Sequencer

This block is the sequencing core of an on-chip debug unit. Software arms it, and it then walks through three numbered active states. Each move is driven by matches reported by a set of comparator channels. A session ends by passing through a final state. On the way out the block may pulse a trigger to a trace unit and may raise a breakpoint request. It then disarms itself, either at once or, when tracing is enabled, once the trace unit reports that it has finished. Address and data comparison, bus decoding and the trace storage all sit outside the block. It sees only one match bit per channel.

Each channel carries two independent enables. The first lets a match move the sequencer to that channel's 2-bit target state. The second lets a match raise a breakpoint straight away, outside the sequencer. Software can force the end of a session with a trigger bit, and it can abort a session at any time by clearing the arm bit.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, seqState is 0, armed is 0, and brkReq and traceTrig are 0.
- R2: A pulse on armSet while the block is disarmed in state 0 sets armed and moves seqState to 1 on the next clock. armSet has no effect while armed is 1.
- R3: seqState always holds the current state, encoded as 0 = disarmed/idle, 1..3 = active states, 4 = final state. It never takes any other value.
- R4: In states 1..3, a match on a channel whose chToSeq bit is set moves the sequencer on the next clock to that channel's target, held in chTarget[2i+1:2i]. The move may go to any of 1..3 in any order, and target 0 means the final state. When several such channels match, the lowest index wins.
- R5: A swTrig pulse in states 1..3 moves the sequencer to the final state on the next clock, whatever the matches are. In state 0 it is ignored.
- R6: In states 1..3, a match on a channel whose chBrkEn bit is set gives a one-clock brkReq pulse on the next clock. If that channel's chToSeq bit is clear, the state is unchanged.
- R7: The final state lasts exactly one clock and is always followed by state 0.
- R8: With traceEn at 0, the clock spent in the final state shows brkReq = brkOnEnd and traceTrig = 0. armed drops to 0 as state 0 is entered.
- R9: With traceEn at 1, traceTrig pulses during the final-state clock, and armed stays 1 in state 0. The clock after traceDone is sampled, armed drops to 0 and brkReq pulses if brkOnEnd is set.
- R10: With traceEn and brkOnEnd both 0, the final state returns to state 0 disarmed and raises neither brkReq nor traceTrig.
- R11: armClr forces seqState to 0 and armed to 0 on the next clock, in any state, and takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armSet | input | 1 | Software write of 1 to the arm bit (pulse) |
| armClr | input | 1 | Software write of 0 to the arm bit (pulse) |
| swTrig | input | 1 | Software trigger (pulse) |
| chMatch | input | NUM_CH | Per-channel comparator match |
| chToSeq | input | NUM_CH | Per-channel enable: a match drives a state change |
| chTarget | input | 2*NUM_CH | Per-channel 2-bit target state, channel i at [2i+1:2i], 0 = final |
| chBrkEn | input | NUM_CH | Per-channel immediate breakpoint enable |
| traceEn | input | 1 | Tracing enabled for the session |
| traceDone | input | 1 | Trace unit reports that the trace session is complete |
| brkOnEnd | input | 1 | Raise a breakpoint when the session ends |
| seqState | output | 3 | Current state: 0 idle, 1..3 active, 4 final |
| armed | output | 1 | Arm bit, set by armSet and cleared by hardware or armClr |
| brkReq | output | 1 | Breakpoint request pulse |
| traceTrig | output | 1 | Trace trigger pulse |

## Verification
The bound checker tests on every clock that the state stays legal, and that the final state is always followed by state 0. It also checks that an active state implies armed, that armClr and armSet take effect on the next clock, that an enabled breakpoint channel produces brkReq, and that traceTrig appears only in the final state. Other behaviour can only be seen through the bench's scenarios: the lowest-index priority among matching channels, backward moves between active states, the arm bit staying set until a delayed traceDone, the breakpoint that comes with it, and the way these interact under random stimulus.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int TGT_W = 2;
  localparam int ST_W  = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_A1    = 3'd1,
    ST_A2    = 3'd2,
    ST_A3    = 3'd3,
    ST_FINAL = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armLoad;
    logic armDrop;
    logic brkFire;
    logic trigFire;
  } seqStrobe_t;
endpackage

// File: rtl/dbg_seq_datapath.sv
module dbg_seq_datapath
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chMatch,
  input  logic [NUM_CH-1:0]       chToSeq,
  input  logic [TGT_W*NUM_CH-1:0] chTarget,
  input  logic [NUM_CH-1:0]       chBrkEn,
  input  seqStrobe_t              stb,
  output logic                    seqHit,
  output logic [TGT_W-1:0]        seqTarget,
  output logic                    brkHit,
  output logic                    armed,
  output logic                    brkReq,
  output logic                    traceTrig
);
  logic [NUM_CH-1:0] seqQual;
  logic [NUM_CH-1:0] brkQual;

  // qualify each channel's match against its two enables
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign seqQual[g] = chMatch[g] & chToSeq[g];
    assign brkQual[g] = chMatch[g] & chBrkEn[g];
  end

  assign brkHit = |brkQual;

  // lowest-index sequencing channel wins
  always_comb begin
    seqHit    = 1'b0;
    seqTarget = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (seqQual[i]) begin
        seqHit    = 1'b1;
        seqTarget = chTarget[TGT_W*i +: TGT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      brkReq    <= 1'b0;
      traceTrig <= 1'b0;
    end else begin
      if (stb.armLoad)      armed <= 1'b1;
      else if (stb.armDrop) armed <= 1'b0;
      brkReq    <= stb.brkFire;
      traceTrig <= stb.trigFire;
    end
  end
endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             armSet,
  input  logic             armClr,
  input  logic             swTrig,
  input  logic             traceEn,
  input  logic             traceDone,
  input  logic             brkOnEnd,
  input  logic             armed,
  input  logic             seqHit,
  input  logic [TGT_W-1:0] seqTarget,
  input  logic             brkHit,
  output seqStrobe_t       stb,
  output logic [ST_W-1:0]  seqState
);
  seqState_t curSt, nxtSt;
  logic      goFinal;

  always_comb begin
    nxtSt   = curSt;
    stb     = '0;
    goFinal = 1'b0;
    if (armClr) begin
      nxtSt       = ST_IDLE;
      stb.armDrop = 1'b1;
    end else begin
      unique case (curSt)
        ST_IDLE: begin
          if (!armed && armSet) begin
            nxtSt       = ST_A1;
            stb.armLoad = 1'b1;
          end else if (armed && traceDone) begin
            stb.armDrop = 1'b1;
            stb.brkFire = brkOnEnd;
          end
        end
        ST_A1, ST_A2, ST_A3: begin
          stb.brkFire = brkHit;
          if (swTrig) begin
            goFinal = 1'b1;
          end else if (seqHit) begin
            if (seqTarget == '0) goFinal = 1'b1;
            else                 nxtSt   = seqState_t'({1'b0, seqTarget});
          end
          if (goFinal) begin
            nxtSt        = ST_FINAL;
            stb.trigFire = traceEn;
            if (!traceEn) stb.brkFire = stb.brkFire | brkOnEnd;
          end
        end
        ST_FINAL: begin
          nxtSt = ST_IDLE;
          if (!traceEn) stb.armDrop = 1'b1;
        end
        default: nxtSt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curSt <= ST_IDLE;
    else       curSt <= nxtSt;
  end

  assign seqState = curSt;
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  armSet,
  input  logic                  armClr,
  input  logic                  swTrig,
  input  logic [NUM_CH-1:0]     chMatch,
  input  logic [NUM_CH-1:0]     chToSeq,
  input  logic [2*NUM_CH-1:0]   chTarget,
  input  logic [NUM_CH-1:0]     chBrkEn,
  input  logic                  traceEn,
  input  logic                  traceDone,
  input  logic                  brkOnEnd,
  output logic [2:0]            seqState,
  output logic                  armed,
  output logic                  brkReq,
  output logic                  traceTrig
);
  seqStrobe_t       stb;
  logic             seqHit;
  logic [TGT_W-1:0] seqTarget;
  logic             brkHit;

  dbg_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr),
    .swTrig(swTrig), .traceEn(traceEn), .traceDone(traceDone),
    .brkOnEnd(brkOnEnd), .armed(armed), .seqHit(seqHit),
    .seqTarget(seqTarget), .brkHit(brkHit), .stb(stb),
    .seqState(seqState)
  );

  dbg_seq_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .chMatch(chMatch), .chToSeq(chToSeq),
    .chTarget(chTarget), .chBrkEn(chBrkEn), .stb(stb),
    .seqHit(seqHit), .seqTarget(seqTarget), .brkHit(brkHit),
    .armed(armed), .brkReq(brkReq), .traceTrig(traceTrig)
  );
endmodule

// File: rtl/dbg_seq_checker.sv
module dbg_seq_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              armSet,
  input logic              armClr,
  input logic              swTrig,
  input logic [NUM_CH-1:0] chMatch,
  input logic [NUM_CH-1:0] chBrkEn,
  input logic              traceEn,
  input logic [2:0]        seqState,
  input logic              armed,
  input logic              brkReq,
  input logic              traceTrig
);
  logic activeSt;
  assign activeSt = (seqState != 3'd0) && (seqState != 3'd4);

  p_legal_state_r3: assert property (@(posedge clk) disable iff (!rstN)
    seqState <= 3'd4);

  p_final_one_clock_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqState == 3'd4 |=> seqState == 3'd0);

  p_arm_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd0 && !armed && armSet && !armClr) |=> (seqState == 3'd1 && armed));

  p_clear_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    armClr |=> (seqState == 3'd0 && !armed));

  p_active_armed_r3: assert property (@(posedge clk) disable iff (!rstN)
    seqState != 3'd0 |-> armed);

  p_chan_brk_r6: assert property (@(posedge clk) disable iff (!rstN)
    (activeSt && |(chMatch & chBrkEn) && !armClr) |=> brkReq);

  p_swtrig_final_r5: assert property (@(posedge clk) disable iff (!rstN)
    (activeSt && swTrig && !armClr) |=> seqState == 3'd4);

  p_trig_in_final_r9: assert property (@(posedge clk) disable iff (!rstN)
    traceTrig |-> seqState == 3'd4);

  p_notrace_disarm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd4 && !traceEn) |=> !armed);
endmodule

bind dbg_seq_top dbg_seq_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr),
  .swTrig(swTrig), .chMatch(chMatch), .chBrkEn(chBrkEn),
  .traceEn(traceEn), .seqState(seqState), .armed(armed),
  .brkReq(brkReq), .traceTrig(traceTrig)
);

// File: tb/tb_dbg_seq_top.sv
module tb_dbg_seq_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armSet = 0, armClr = 0, swTrig = 0;
  logic [NCH-1:0] chMatch = '0, chToSeq = '0, chBrkEn = '0;
  logic [2*NCH-1:0] chTarget = '0;
  logic traceEn = 0, traceDone = 0, brkOnEnd = 0;
  logic [2:0] seqState;
  logic armed, brkReq, traceTrig;

  int nRun = 0, nFail = 0;
  bit done = 0;

  // reference model state
  int mS = 0;
  bit mA = 0, mB = 0, mT = 0;

  always #10 clk = ~clk;

  dbg_seq_top #(.NUM_CH(NCH)) dut (
    .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr),
    .swTrig(swTrig), .chMatch(chMatch), .chToSeq(chToSeq),
    .chTarget(chTarget), .chBrkEn(chBrkEn), .traceEn(traceEn),
    .traceDone(traceDone), .brkOnEnd(brkOnEnd), .seqState(seqState),
    .armed(armed), .brkReq(brkReq), .traceTrig(traceTrig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // next-state of the model, taken from the requirements
  task automatic modelStep();
    int nS = mS;
    bit nA = mA, nB = 0, nT = 0, fin = 0, found = 0;
    int tgt = 0;
    if (armClr) begin
      nS = 0; nA = 0;                                  // R11
    end else if (mS == 0) begin
      if (!mA && armSet) begin nS = 1; nA = 1; end     // R2
      else if (mA && traceDone) begin nA = 0; nB = brkOnEnd; end // R9
    end else if (mS == 4) begin
      nS = 0;                                          // R7
      if (!traceEn) nA = 0;                            // R8 R10
    end else begin
      nB = |(chMatch & chBrkEn);                       // R6
      for (int i = 0; i < NCH; i++)
        if (!found && chMatch[i] && chToSeq[i]) begin
          found = 1; tgt = chTarget[2*i +: 2];
        end
      if (swTrig) fin = 1;                             // R5
      else if (found) begin
        if (tgt == 0) fin = 1; else nS = tgt;          // R4
      end
      if (fin) begin
        nS = 4; nT = traceEn;
        if (!traceEn) nB = nB | brkOnEnd;
      end
    end
    mS = nS; mA = nA; mB = nB; mT = nT;
  endtask

  // one clock: inputs already set at negedge; compare at following negedge
  task automatic tick(input string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " state"}, seqState, mS);
    chk({tag, " armed"}, armed, mA);
    chk({tag, " brk"}, brkReq, mB);
    chk({tag, " trig"}, traceTrig, mT);
    armSet = 0; armClr = 0; swTrig = 0; chMatch = '0; traceDone = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 state", seqState, 0);
    chk("R1 armed", armed, 0);
    chk("R1 brk", brkReq, 0);
    rstN = 1;
    @(negedge clk);

    // R2 arm
    armSet = 1; tick("R2 arm");
    chk("R2 s1", seqState, 1);
    armSet = 1; tick("R2 rearm ignored");
    chk("R2 stay", seqState, 1);

    // R4 priority and free order: ch0->2, ch1->3, ch3->final
    chToSeq = 4'b1011;
    chTarget = {2'd0, 2'd1, 2'd3, 2'd2};
    chMatch = 4'b0011; tick("R4 prio");
    chk("R4 lowest wins", seqState, 2);
    chMatch = 4'b0010; tick("R4 fwd");
    chk("R4 to3", seqState, 3);
    chMatch = 4'b0001; tick("R4 back");
    chk("R4 to2", seqState, 2);

    // R6 breakpoint channel not sequencing
    chBrkEn = 4'b0100;
    chMatch = 4'b0100; tick("R6 brk");
    chk("R6 brkReq", brkReq, 1);
    chk("R6 state kept", seqState, 2);

    // R5 / R8 no-trace end with brkOnEnd
    brkOnEnd = 1; swTrig = 1; tick("R5 swtrig");
    chk("R5 final", seqState, 4);
    chk("R8 brk in final", brkReq, 1);
    chk("R8 no trig", traceTrig, 0);
    tick("R7 leave final");
    chk("R7 idle", seqState, 0);
    chk("R8 disarmed", armed, 0);
    swTrig = 1; tick("R5 idle ignored");
    chk("R5 idle", seqState, 0);

    // R9 trace enabled, end by channel 3 target 0
    traceEn = 1; brkOnEnd = 1;
    armSet = 1; tick("R9 arm");
    chMatch = 4'b1000; tick("R9 final");
    chk("R9 trig", traceTrig, 1);
    chk("R9 no brk yet", brkReq, 0);
    tick("R9 idle");
    chk("R9 still armed", armed, 1);
    tick("R9 wait");
    traceDone = 1; tick("R9 done");
    chk("R9 disarm", armed, 0);
    chk("R9 brk", brkReq, 1);

    // R10 neither enabled
    traceEn = 0; brkOnEnd = 0;
    armSet = 1; tick("R10 arm");
    swTrig = 1; tick("R10 final");
    chk("R10 no brk", brkReq, 0);
    tick("R10 idle");
    chk("R10 disarm", armed, 0);

    // R11 abort from active state, and priority over armSet
    armSet = 1; tick("R11 arm");
    chMatch = 4'b0001; tick("R11 s2");
    armClr = 1; swTrig = 1; tick("R11 clr");
    chk("R11 idle", seqState, 0);
    chk("R11 disarm", armed, 0);
    armClr = 1; armSet = 1; tick("R11 prio");
    chk("R11 beats arm", armed, 0);

    // random mix, R3 R4 R6 R9 against the model
    for (int n = 0; n < 3000; n++) begin
      armSet   = ($urandom % 8) == 0;
      armClr   = ($urandom % 40) == 0;
      swTrig   = ($urandom % 16) == 0;
      chMatch  = $urandom;
      chToSeq  = $urandom;
      chBrkEn  = $urandom;
      chTarget = $urandom;
      traceDone = ($urandom % 6) == 0;
      if (mS == 0 && !mA) begin
        traceEn  = $urandom;
        brkOnEnd = $urandom;
      end
      tick("R3 random");
      chk("R3 legal", int'(seqState <= 3'd4), 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule